// File: doc/BRIEF.md
# Divergent-Branch Lane Rejoin Unit

This unit keeps the active-lane mask of one SIMD warp while the warp runs through divergent branches. It does not use a mask stack. Each lane has one parking slot, which holds a flag and a resume address. A lane that leaves the warp's current path parks with the address where it will rejoin. The warp then runs on with the lanes that remain. No warp swap or context switch is needed for this. A parked lane comes back in the same update in which the warp's next fetch address reaches or passes its resume address. Because every lane holds only one address, nesting depth has no fixed bound and nothing has to be unwound.

The issue stage presents each instruction with `instr_valid`, its address on `instr_pc`, and branch information when the instruction is a branch. The unit takes every issued instruction in the cycle it is presented. It never holds off the issue stage, so the instruction interface has a valid strobe and no ready signal. There is no back-pressure at all. On each issued instruction the unit registers three things: the mask for the next instruction, the address to fetch next, and a flag. The flag shows that no lane was left on the path and that the warp was redirected to the lowest resume address. At a split the warp follows the fall-through path first. Lanes that take the branch park at the target. Divergent targets must lie ahead of the branch in program order, and every split must eventually reach its rejoin point. Per-instruction predication, fetch and scheduling are handled outside this unit.

Top module: `rejoin_unit`

## Requirements
- R1: After reset, all 32 bits of `active_mask` are 1, `next_pc` is 0, `path_empty` is 0 and no lane is parked. After `launch`, the same holds except that `next_pc` equals `launch_pc`.
- R2: In a cycle with `instr_valid` low and `launch` low, the outputs and the parked state do not change, whatever values the branch inputs carry.
- R3: An issued instruction that is not a branch sets `next_pc` to `instr_pc + 4`, leaves the mask unchanged and clears `path_empty`.
- R4: A branch that no active lane takes acts like R3.
- R5: A branch that every active lane takes, with no parked lane resuming at or below the target, sets `next_pc` to `br_target`, leaves the mask unchanged and sets `path_empty` to 1.
- R6: A split branch removes the active lanes that take it from the mask. Those lanes park with `br_target` as their resume address, and `next_pc` becomes `instr_pc + 4`.
- R7: A parked lane rejoins the mask in the same update in which the new `next_pc` is at or above its resume address (unsigned comparison). Its slot is then cleared.
- R8: When no active lane stays on the path, `next_pc` becomes the lowest resume address among all parked lanes, counting those parked by this instruction. Every lane parked at that address rejoins, and `path_empty` is set to 1.
- R9: `active_mask` is never all zeros, and no lane is both active and parked.
- R10: `launch` takes priority over `instr_valid` in the same cycle and discards every parked lane, so an earlier resume address has no later effect.
- R11: Bits of `br_taken` that belong to inactive lanes have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| launch | input | 1 | Starts the warp: all lanes active, all slots cleared |
| launch_pc | input | 32 | First fetch address after `launch` |
| instr_valid | input | 1 | An instruction is issued this cycle |
| instr_pc | input | 32 | Address of the issued instruction |
| br_valid | input | 1 | The issued instruction is a divergent-capable branch |
| br_taken | input | 32 | Per-lane branch outcome, bit i for lane i |
| br_target | input | 32 | Branch target address |
| active_mask | output | 32 | Registered mask of lanes that run the next instruction |
| next_pc | output | 32 | Registered address to fetch next |
| path_empty | output | 1 | Last issued instruction left no lane on the path |

## Verification
Some rules are checked by properties on every cycle. The mask is never empty and never overlaps the parked set. The outputs hold still when nothing is issued. A launch brings all lanes back. A non-branch instruction or a uniform not-taken branch steps the address by one instruction. A parked lane keeps its address until it wakes, and its slot is cleared when it wakes. The exact order in which lanes come back depends on sequences of addresses over many cycles: if/else shapes, nested splits, skip-ahead jumps to the lowest parked address, and a launch in the middle of a split. Only the bench's scenarios, compared against a step-by-step reference model, can show that.

// File: rtl/rejoin_pkg.sv
package rejoin_pkg;
  localparam int unsigned LANES_DEFAULT = 32;
  localparam int unsigned ADDR_W_DEFAULT = 32;
  localparam int unsigned INSTR_BYTES_DEFAULT = 4;

  // where the next fetch address comes from
  typedef enum logic [0:0] {
    NPC_SEQUENTIAL = 1'b0,
    NPC_LOWEST_PARKED = 1'b1
  } npc_src_e;
endpackage

// File: rtl/rejoin_lane.sv
module rejoin_lane #(
  parameter int unsigned ADDR_W = rejoin_pkg::ADDR_W_DEFAULT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic              issue,
  input  logic              park_en,
  input  logic [ADDR_W-1:0] park_addr,
  input  logic [ADDR_W-1:0] wake_pc,
  output logic              pend_valid,
  output logic [ADDR_W-1:0] pend_addr,
  output logic              wake,
  output logic              parked
);
  logic              parked_q;
  logic [ADDR_W-1:0] addr_q;

  // slot contents after this instruction's park, before the wake test
  always_comb begin
    pend_valid = parked_q | park_en;
    pend_addr  = park_en ? park_addr : addr_q;
    wake       = pend_valid && (pend_addr <= wake_pc);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || launch) begin
      parked_q <= 1'b0;
      addr_q   <= '0;
    end else if (issue) begin
      parked_q <= pend_valid & ~wake;
      addr_q   <= (pend_valid & ~wake) ? pend_addr : '0;
    end
  end

  assign parked = parked_q;

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (parked_q && !launch && !park_en) |=> (!parked_q || $stable(addr_q))); // R6

  AST_WAKE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && !launch && wake) |=> (!parked_q && addr_q == '0)); // R7
endmodule

// File: rtl/rejoin_min.sv
module rejoin_min #(
  parameter int unsigned LANES  = rejoin_pkg::LANES_DEFAULT,
  parameter int unsigned ADDR_W = rejoin_pkg::ADDR_W_DEFAULT
) (
  input  logic [LANES-1:0]        valid,
  input  logic [LANES*ADDR_W-1:0] addrs,
  output logic                    found,
  output logic [ADDR_W-1:0]       min_addr
);
  always_comb begin
    found    = 1'b0;
    min_addr = '1;
    for (int i = 0; i < LANES; i++) begin
      if (valid[i] && (!found || addrs[i*ADDR_W +: ADDR_W] < min_addr)) begin
        found    = 1'b1;
        min_addr = addrs[i*ADDR_W +: ADDR_W];
      end
    end
  end
endmodule

// File: rtl/rejoin_unit.sv
module rejoin_unit #(
  parameter int unsigned LANES       = rejoin_pkg::LANES_DEFAULT,
  parameter int unsigned ADDR_W      = rejoin_pkg::ADDR_W_DEFAULT,
  parameter int unsigned INSTR_BYTES = rejoin_pkg::INSTR_BYTES_DEFAULT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic [ADDR_W-1:0] launch_pc,
  input  logic              instr_valid,
  input  logic [ADDR_W-1:0] instr_pc,
  input  logic              br_valid,
  input  logic [LANES-1:0]  br_taken,
  input  logic [ADDR_W-1:0] br_target,
  output logic [LANES-1:0]  active_mask,
  output logic [ADDR_W-1:0] next_pc,
  output logic              path_empty
);
  import rejoin_pkg::*;

  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INSTR_BYTES);

  logic [LANES-1:0]        active_q;
  logic [ADDR_W-1:0]       npc_q;
  logic                    empty_q;
  logic                    issue;
  logic [LANES-1:0]        take_act, stay, park_vec;
  logic [LANES-1:0]        pend_vec, wake_vec, parked_vec;
  logic [LANES*ADDR_W-1:0] pend_addrs;
  logic                    empty_now, min_found;
  logic [ADDR_W-1:0]       min_addr, cand_pc;
  npc_src_e                npc_src;

  always_comb begin
    issue     = instr_valid & ~launch;
    take_act  = br_valid ? (active_q & br_taken) : '0;
    stay      = active_q & ~take_act;
    park_vec  = issue ? take_act : '0;
    empty_now = (stay == '0);
    npc_src   = empty_now ? NPC_LOWEST_PARKED : NPC_SEQUENTIAL;
    cand_pc   = (npc_src == NPC_LOWEST_PARKED) ? min_addr : instr_pc + STEP;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    rejoin_lane #(.ADDR_W(ADDR_W)) u_lane (
      .clk       (clk),
      .rst_n     (rst_n),
      .launch    (launch),
      .issue     (issue),
      .park_en   (park_vec[g]),
      .park_addr (br_target),
      .wake_pc   (cand_pc),
      .pend_valid(pend_vec[g]),
      .pend_addr (pend_addrs[g*ADDR_W +: ADDR_W]),
      .wake      (wake_vec[g]),
      .parked    (parked_vec[g])
    );
  end

  rejoin_min #(.LANES(LANES), .ADDR_W(ADDR_W)) u_min (
    .valid   (pend_vec),
    .addrs   (pend_addrs),
    .found   (min_found),
    .min_addr(min_addr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= '1;
      npc_q    <= '0;
      empty_q  <= 1'b0;
    end else if (launch) begin
      active_q <= '1;
      npc_q    <= launch_pc;
      empty_q  <= 1'b0;
    end else if (issue) begin
      active_q <= stay | wake_vec;
      npc_q    <= cand_pc;
      empty_q  <= empty_now;
    end
  end

  assign active_mask = active_q;
  assign next_pc     = npc_q;
  assign path_empty  = empty_q;

  AST_MASK_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    issue |=> (active_mask != '0)); // R9

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q & parked_vec) == '0); // R9

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!instr_valid && !launch) |=> ($stable(active_mask) && $stable(next_pc) && $stable(path_empty))); // R2

  AST_LAUNCH_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> ((&active_mask) && parked_vec == '0 && !path_empty)); // R10

  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && !(br_valid && |(active_mask & br_taken))) |=> (next_pc == $past(instr_pc) + STEP && !path_empty)); // R3

  AST_REJOIN_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && empty_now) |-> min_found); // R8
endmodule

// File: tb/rejoin_unit_tb.sv
module rejoin_unit_tb;
  localparam int L = 32;
  localparam int AW = 32;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n, launch, instr_valid, br_valid;
  logic [AW-1:0] launch_pc, instr_pc, br_target;
  logic [L-1:0]  br_taken;
  logic [L-1:0]  active_mask;
  logic [AW-1:0] next_pc;
  logic          path_empty;

  rejoin_unit u_dut (
    .clk(clk), .rst_n(rst_n), .launch(launch), .launch_pc(launch_pc),
    .instr_valid(instr_valid), .instr_pc(instr_pc), .br_valid(br_valid),
    .br_taken(br_taken), .br_target(br_target), .active_mask(active_mask),
    .next_pc(next_pc), .path_empty(path_empty)
  );

  int checks = 0;
  int fails = 0;

  // reference model state
  logic [L-1:0]  m_mask;
  bit            m_park [L];
  logic [AW-1:0] m_addr [L];
  logic [AW-1:0] m_pc;
  bit            m_empty;

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic compare(string req);
    chk(req, "active_mask", 64'(active_mask), 64'(m_mask));
    chk(req, "next_pc", 64'(next_pc), 64'(m_pc));
    chk(req, "path_empty", 64'(path_empty), 64'(m_empty));
  endtask

  task automatic model_clear(logic [AW-1:0] pc);
    m_mask = '1; m_pc = pc; m_empty = 0;
    for (int i = 0; i < L; i++) begin m_park[i] = 0; m_addr[i] = '0; end
  endtask

  task automatic model_step(logic [AW-1:0] pc, bit bv, logic [L-1:0] bt, logic [AW-1:0] tgt);
    logic [L-1:0] take, stay;
    logic [AW-1:0] nxt;
    bit any;
    take = bv ? (m_mask & bt) : '0;
    stay = m_mask & ~take;
    for (int i = 0; i < L; i++) if (take[i]) begin m_park[i] = 1; m_addr[i] = tgt; end
    if (stay == '0) begin
      any = 0; nxt = '0;
      for (int i = 0; i < L; i++)
        if (m_park[i] && (!any || m_addr[i] < nxt)) begin any = 1; nxt = m_addr[i]; end
    end else nxt = pc + 4;
    m_mask = stay;
    for (int i = 0; i < L; i++)
      if (m_park[i] && m_addr[i] <= nxt) begin m_park[i] = 0; m_addr[i] = '0; m_mask[i] = 1'b1; end
    m_pc = nxt;
    m_empty = (stay == '0);
  endtask

  // one clock: drive at negedge, compare at the following negedge
  task automatic cyc(bit v, bit bv, logic [L-1:0] bt, logic [AW-1:0] tgt, string req);
    instr_valid = v; instr_pc = m_pc; br_valid = bv; br_taken = bt; br_target = tgt;
    if (v) model_step(m_pc, bv, bt, tgt);
    @(posedge clk);
    @(negedge clk);
    compare(req);
    instr_valid = 0; br_valid = 0;
  endtask

  task automatic run_to(logic [AW-1:0] stop_pc, string req);
    while (m_pc != stop_pc) cyc(1, 0, '0, '0, req);
  endtask

  task automatic do_launch(logic [AW-1:0] pc, string req);
    launch = 1; launch_pc = pc; instr_valid = 1; instr_pc = m_pc;
    br_valid = 1; br_taken = '1; br_target = 32'h0000_0FF0;
    model_clear(pc);
    @(posedge clk);
    @(negedge clk);
    compare(req);
    launch = 0; instr_valid = 0; br_valid = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst_n = 0; launch = 0; launch_pc = '0; instr_valid = 0; instr_pc = '0;
    br_valid = 0; br_taken = '0; br_target = '0;
    model_clear('0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    compare("R1");

    do_launch(32'h100, "R1");

    // R2: branch inputs toggle while nothing is issued
    cyc(0, 1, '1, 32'h999, "R2");
    cyc(0, 1, 32'h0F0F_0F0F, 32'h104, "R2");
    chk("R2", "next_pc held", 64'(next_pc), 64'h100);

    // R3: straight-line code
    cyc(1, 0, '0, '0, "R3"); cyc(1, 0, '0, '0, "R3"); cyc(1, 0, '0, '0, "R3");
    chk("R3", "next_pc step", 64'(next_pc), 64'h10C);

    // R4: branch nobody takes
    cyc(1, 1, '0, 32'h180, "R4");
    chk("R4", "fallthrough", 64'(next_pc), 64'h110);

    // R5: uniform taken
    cyc(1, 1, '1, 32'h200, "R5");
    chk("R5", "target", 64'(next_pc), 64'h200);
    chk("R5", "path_empty", 64'(path_empty), 64'h1);

    // R6: even lanes take
    cyc(1, 1, 32'h5555_5555, 32'h240, "R6");
    chk("R6", "mask split", 64'(active_mask), 64'hAAAA_AAAA);
    chk("R6", "next_pc", 64'(next_pc), 64'h204);

    // R11: only parked lanes claim the branch
    cyc(1, 1, 32'h5555_5555, 32'h300, "R11");
    chk("R11", "mask unchanged", 64'(active_mask), 64'hAAAA_AAAA);
    chk("R11", "fallthrough", 64'(next_pc), 64'h208);

    // R7: walk to the rejoin point
    run_to(32'h240, "R7");
    chk("R7", "all rejoined", 64'(active_mask), 64'hFFFF_FFFF);

    // R8: if/else shape
    cyc(1, 1, 32'h0000_FFFF, 32'h280, "R8");
    cyc(1, 1, 32'hFFFF_0000, 32'h2C0, "R8");
    chk("R8", "else lanes", 64'(active_mask), 64'h0000_FFFF);
    chk("R8", "skip to lowest", 64'(next_pc), 64'h280);
    chk("R8", "path_empty", 64'(path_empty), 64'h1);
    run_to(32'h2C0, "R7");
    chk("R7", "joined after else", 64'(active_mask), 64'hFFFF_FFFF);

    // R8: nested splits
    cyc(1, 1, 32'h0000_00FF, 32'h400, "R8");
    cyc(1, 1, 32'h0000_FF00, 32'h380, "R8");
    cyc(1, 1, 32'hFFFF_0000, 32'h3F0, "R8");
    chk("R8", "nested lowest", 64'(next_pc), 64'h380);
    chk("R8", "nested mask", 64'(active_mask), 64'h0000_FF00);
    run_to(32'h3F0, "R7");
    chk("R7", "partial rejoin", 64'(active_mask), 64'hFFFF_FF00);
    run_to(32'h400, "R7");
    chk("R7", "full rejoin", 64'(active_mask), 64'hFFFF_FFFF);

    // R10: launch during a split discards parked lanes
    cyc(1, 1, 32'hF000_000F, 32'h500, "R10");
    do_launch(32'h480, "R10");
    run_to(32'h500, "R10");
    cyc(1, 0, '0, '0, "R10");
    chk("R10", "no stale rejoin", 64'(active_mask), 64'hFFFF_FFFF);

    // random forward-branching traffic against the model
    for (int n = 0; n < 400; n++) begin
      bit v, bv;
      logic [L-1:0] bt;
      v = ($urandom % 4) != 0;
      bv = ($urandom % 2) != 0;
      bt = (($urandom % 3) == 0) ? '1 : $urandom;
      cyc(v, bv, bt, m_pc + 32'(4 * (2 + $urandom % 8)), "R6");
      chk("R9", "mask nonzero", 64'(active_mask != '0), 64'h1);
      if ((n % 100) == 99) do_launch(32'h1000, "R10");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule